// File: doc/BRIEF.md
# Tapped Segmented Shift Register

This block is a long serial shift register split into equal segments. A tap sits at the end of each segment. In shift mode the whole chain moves one stage per rising clock edge, and every tap drives out the last stage of its segment. In load mode the taps between segments turn into inputs. Each one feeds the first stage of the next segment, so all segments fill in parallel. With the default sizes, 64 bits enter in 16 clocks.

The serial input always feeds the first stage. The last tap has no input path. Each tap is modelled as a separate input, output and output-enable signal. A pad or bus wrapper outside the block can then combine them into a three-state pin. For two channels, instantiate the block twice.

Top module: `tap_shift_reg`

## Requirements
- R1: An active-low reset (rst_ni = 0) clears every stage to 0, so all taps read 0 during and right after reset.
- R2: On every rising clock edge the first stage of segment 0 takes ser_i, in both modes.
- R3: With wr_en_i = 0, every rising edge moves each stage into the next one, across segment boundaries. A bit applied at ser_i before the first edge shows on tap_o[k] after exactly SEG_LEN*(k+1) edges.
- R4: With wr_en_i = 1, the first stage of segment k (k >= 1) takes tap_i[k-1] on the rising edge, instead of the last stage of segment k-1.
- R5: In load mode a pattern of SEG_LEN*NUM_SEG bits enters in SEG_LEN edges. It then reads out of tap_o[NUM_SEG-1] in shift mode, one bit per edge, starting from the last stage and moving back toward stage 1.
- R6: tap_oe_o is all ones while wr_en_i = 0 and all zeros while wr_en_i = 1. It follows wr_en_i combinationally.
- R7: tap_i has no effect while wr_en_i = 0.
- R8: tap_o[k] always carries the content of stage SEG_LEN*(k+1), counting stages from 1 at the serial input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the block acts on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data into stage 1 |
| wr_en_i | input | 1 | 1 = load through the taps, 0 = plain shift |
| tap_i | input | NUM_SEG-1 | Tap inputs; bit k-1 feeds the first stage of segment k |
| tap_o | output | NUM_SEG | Tap outputs; bit k is the last stage of segment k |
| tap_oe_o | output | NUM_SEG | Output enables for the taps |

## Verification
The bench builds the block with SEG_LEN = 16 and NUM_SEG = 4. At these sizes the latencies of 16, 32, 48 and 64 edges and the full 64-bit load in 16 clocks are short enough to sweep completely in one run. Every segment boundary is crossed in both modes, with the tap inputs both idle and active. The behavioural reference is compared against all four taps and their enables on every edge.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } tsr_mode_e;
endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int unsigned SEG_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic head_o,
  output logic tail_o
);
  logic [SEG_LEN-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[SEG_LEN-2:0], din_i};
  end

  assign head_o = stg_q[0];
  assign tail_o = stg_q[SEG_LEN-1];

  assert_head_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> head_o == $past(din_i));

  assert_tail_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tail_o == $past(stg_q[SEG_LEN-2]));
endmodule

// File: rtl/tsr_tap_ctrl.sv
module tsr_tap_ctrl
  import tsr_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               wr_en_i,
  input  logic               ser_i,
  input  logic [NUM_SEG-2:0] tap_i,
  input  logic [NUM_SEG-2:0] seg_tail_i,
  output logic [NUM_SEG-1:0] seg_din_o,
  output logic [NUM_SEG-1:0] tap_oe_o
);
  tsr_mode_e mode;
  assign mode = wr_en_i ? MODE_LOAD : MODE_SHIFT;

  assign seg_din_o[0] = ser_i;

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_mux
    assign seg_din_o[k] = (mode == MODE_LOAD) ? tap_i[k-1] : seg_tail_i[k-1];
  end

  assign tap_oe_o = (mode == MODE_SHIFT) ? '1 : '0;

  always_comb begin
    assert_oe_load_R6: assert (!wr_en_i || tap_oe_o == '0);
    assert_oe_shift_R6: assert (wr_en_i || &tap_oe_o);
  end
endmodule

// File: rtl/tap_shift_reg.sv
module tap_shift_reg #(
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_i,
  input  logic               wr_en_i,
  input  logic [NUM_SEG-2:0] tap_i,
  output logic [NUM_SEG-1:0] tap_o,
  output logic [NUM_SEG-1:0] tap_oe_o
);
  logic [NUM_SEG-1:0] seg_din;
  logic [NUM_SEG-1:0] seg_head;
  logic [NUM_SEG-1:0] seg_tail;

  tsr_tap_ctrl #(.NUM_SEG(NUM_SEG)) u_ctrl (
    .wr_en_i    (wr_en_i),
    .ser_i      (ser_i),
    .tap_i      (tap_i),
    .seg_tail_i (seg_tail[NUM_SEG-2:0]),
    .seg_din_o  (seg_din),
    .tap_oe_o   (tap_oe_o)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    tsr_segment #(.SEG_LEN(SEG_LEN)) u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (seg_din[k]),
      .head_o (seg_head[k]),
      .tail_o (seg_tail[k])
    );
  end

  assign tap_o = seg_tail;

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_chk
    assert_cross_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> seg_head[k] == $past(seg_tail[k-1]));
    assert_cross_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> seg_head[k] == $past(tap_i[k-1]));
  end
endmodule

// File: tb/sim_tap_shift_reg.sv
`timescale 1ns/1ps
module sim_tap_shift_reg;
  localparam int SEG = 16;
  localparam int NS  = 4;
  localparam int TOT = SEG * NS;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ser_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [NS-2:0] tap_i = '0;
  logic [NS-1:0] tap_o;
  logic [NS-1:0] tap_oe_o;

  int total = 0;
  int bad = 0;
  bit mdl[TOT];

  always #2.5 clk = ~clk;

  tap_shift_reg #(.SEG_LEN(SEG), .NUM_SEG(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser_i), .wr_en_i(wr_en_i),
    .tap_i(tap_i), .tap_o(tap_o), .tap_oe_o(tap_oe_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_taps(string req);
    for (int k = 0; k < NS; k++) chk(req, 32'(tap_o[k]), 32'(mdl[(k+1)*SEG-1]));
  endtask

  // called just after a falling edge
  task automatic step(bit s, bit w, logic [NS-2:0] t);
    bit nx[TOT];
    ser_i = s; wr_en_i = w; tap_i = t;
    #1;
    chk("R6", 32'(tap_oe_o), w ? 32'h0 : 32'hF);
    @(posedge clk);
    for (int i = 0; i < TOT; i++) begin
      if (i == 0) nx[i] = s;
      else if (w && (i % SEG) == 0) nx[i] = t[i/SEG-1];
      else nx[i] = mdl[i-1];
    end
    mdl = nx;
    @(negedge clk);
    cmp_taps("R8");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1", 32'(tap_o), 32'h0);
    for (int i = 0; i < TOT; i++) mdl[i] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", 32'(tap_o), 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [TOT-1:0] pat;
    int first[NS];
    @(negedge clk);
    do_reset();

    // R3: latency of one marker bit to each tap
    for (int k = 0; k < NS; k++) first[k] = -1;
    for (int n = 1; n <= TOT; n++) begin
      step(n == 1, 1'b0, '0);
      for (int k = 0; k < NS; k++)
        if (first[k] < 0 && tap_o[k]) first[k] = n;
    end
    for (int k = 0; k < NS; k++) chk("R3", 32'(first[k]), 32'((k+1)*SEG));

    // R7: tap inputs held high in shift mode must not leak in
    for (int n = 0; n < TOT; n++) step(1'b0, 1'b0, '1);
    chk("R7", 32'(tap_o), 32'h0);

    // R2: serial input feeds stage 1 in load mode too
    for (int n = 0; n < SEG; n++) step(1'b1, 1'b1, '0);
    chk("R2", 32'(tap_o[0]), 32'h1);
    chk("R4", 32'(tap_o[NS-1:1]), 32'h0);

    // R4: single mark on tap_i[1] lands at the end of segment 2
    for (int n = 0; n < SEG; n++) step(1'b0, 1'b1, (n == 0) ? 3'b010 : 3'b000);
    chk("R4", 32'(tap_o), 32'b0100);

    // R5: parallel load in SEG clocks, then serial readback from last tap
    pat = 64'hF0E1_D2C3_B4A5_9687;
    for (int j = 0; j < SEG; j++) begin
      logic [NS-2:0] t;
      for (int k = 1; k < NS; k++) t[k-1] = pat[(NS-1-k)*SEG + j];
      step(pat[(NS-1)*SEG + j], 1'b1, t);
    end
    chk("R5", 32'(tap_o[NS-1]), 32'(pat[0]));
    for (int i = 1; i < TOT; i++) begin
      step(1'b0, 1'b0, 3'(i * 5));
      chk("R5", 32'(tap_o[NS-1]), 32'(pat[i]));
    end

    // mixed stream with mode changes
    for (int n = 0; n < 3 * TOT; n++) step(1'((n * 7) >> 2), 1'((n / 5) % 2), 3'(n));

    // R1: reset in mid-run
    @(negedge clk);
    do_reset();
    step(1'b0, 1'b0, '0);
    chk("R1", 32'(tap_o), 32'h0);

    finish_run();
  end
endmodule